// File: doc/BRIEF.md
# Shift, Rotate and Flag-Bit Unit

This block is the 8-bit datapath slice that handles single-operand shifts, rotates through carry, nibble swap, and moves of single bits between a register operand and the T flag of the status byte. It also forces any one status bit to 1 or 0, selected by a 3-bit index.

The caller presents an operand byte, a 4-bit operation code, a bit index and the current status byte, with `valid_i` high. One clock edge later, the block shows three things: the result byte, a write-enable telling the register file whether to store it, and the new status byte. It also raises `done_o`. Register storage and the handling of I/O-space bits belong to the surrounding core.

Top module: `shift_flag_unit`

## Requirements
- R1: Logical shift left (op 0) moves every bit up one place, puts 0 in bit 0 and puts the old bit 7 in C. Logical shift right (op 1) moves every bit down one place, puts 0 in bit 7 and puts the old bit 0 in C.
- R2: Rotate left through carry (op 2) puts the old C in bit 0 and the old bit 7 in C. Rotate right through carry (op 3) puts the old C in bit 7 and the old bit 0 in C.
- R3: Arithmetic shift right (op 4) moves bits 7..1 into bits 6..0, keeps bit 7 and puts the old bit 0 in C.
- R4: For ops 0 to 4, the flags are set as follows: N equals result bit 7, Z is 1 exactly when the result is zero, V = N xor C and S = N xor V. H, T and I keep their values. Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7.
- R5: Swap (op 5) exchanges bits 7..4 with bits 3..0 and leaves the whole status byte unchanged.
- R6: Bit store (op 6) copies operand bit `idx_i` into T (status bit 6). All other status bits are unchanged and the result is not written.
- R7: Bit load (op 7) returns the operand with bit `idx_i` replaced by T and leaves the status byte unchanged.
- R8: Flag set (op 8) forces status bit `idx_i` to 1 and flag clear (op 9) forces it to 0. No other status bit changes and the result is not written.
- R9: `wr_en_o` is 1 for ops 0 to 5 and 7, and 0 for ops 6, 8 and 9. Codes 10 to 15 do nothing: `wr_en_o` is 0, the result equals the operand and the status byte is unchanged.
- R10: The results of a request taken with `valid_i` high appear on the next rising edge, together with `done_o` = 1. Without a request, `done_o` and `wr_en_o` are 0 after the edge. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Request present this cycle |
| op_i | input | 4 | Operation code |
| operand_i | input | 8 | Register operand |
| idx_i | input | 3 | Bit index for bit and flag operations |
| sreg_i | input | 8 | Current status byte |
| result_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Result should be written back |
| sreg_o | output | 8 | Updated status byte |
| done_o | output | 1 | Outputs belong to the previous request |

## Verification
Each result is due exactly one rising edge after the request: the only register on the path is the output stage. The bench drives a request on a falling edge, waits for the next rising edge and samples one time unit later. Before every check it compares `done_o` and `wr_en_o`, and it issues an idle cycle now and then so the return of `done_o` to 0 is also checked at that same offset. The sweep covers every operation code, all 256 operands, several status patterns and rotating indices.

// File: rtl/shift_flag_unit.sv
module shift_flag_unit #(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic [W-1:0]  operand_i,
  input  logic [IW-1:0] idx_i,
  input  logic [7:0]    sreg_i,
  output logic [W-1:0]  result_o,
  output logic          wr_en_o,
  output logic [7:0]    sreg_o,
  output logic          done_o
);
  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FT = 6;
  localparam logic [3:0] OP_SHL = 4'd0, OP_SHR = 4'd1, OP_ROL = 4'd2,
    OP_ROR = 4'd3, OP_ASR = 4'd4, OP_SWP = 4'd5, OP_BST = 4'd6,
    OP_BLD = 4'd7, OP_SET = 4'd8, OP_CLR = 4'd9;

  logic [W-1:0] res;
  logic [7:0]   nf;
  logic         we, co, sh, nbit;

  assign nbit = res[W-1];

  always_comb begin
    res = operand_i;
    nf  = sreg_i;
    we  = 1'b0;
    co  = 1'b0;
    sh  = 1'b0;
    unique case (op_i)
      OP_SHL: begin {co, res} = {operand_i, 1'b0};         sh = 1'b1; end
      OP_SHR: begin {res, co} = {1'b0, operand_i};         sh = 1'b1; end
      OP_ROL: begin {co, res} = {operand_i, sreg_i[FC]};   sh = 1'b1; end
      OP_ROR: begin {res, co} = {sreg_i[FC], operand_i};   sh = 1'b1; end
      OP_ASR: begin {res, co} = {operand_i[W-1], operand_i}; sh = 1'b1; end
      OP_SWP: begin res = {operand_i[W/2-1:0], operand_i[W-1:W/2]}; we = 1'b1; end
      OP_BST: nf[FT] = operand_i[idx_i];
      OP_BLD: begin res[idx_i] = sreg_i[FT]; we = 1'b1; end
      OP_SET: nf[idx_i] = 1'b1;
      OP_CLR: nf[idx_i] = 1'b0;
      default: ;
    endcase
    if (sh) begin
      we     = 1'b1;
      nf[FC] = co;
      nf[FN] = nbit;
      nf[FZ] = (res == '0);
      nf[FV] = nbit ^ co;
      nf[FS] = co;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o <= '0;
      sreg_o   <= '0;
      wr_en_o  <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o  <= valid_i;
      wr_en_o <= valid_i & we;
      if (valid_i) begin
        result_o <= res;
        sreg_o   <= nf;
      end
    end
  end
endmodule

// File: rtl/shift_flag_unit_chk.sv
module shift_flag_unit_chk #(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          valid_i,
  input logic [3:0]    op_i,
  input logic [W-1:0]  operand_i,
  input logic [IW-1:0] idx_i,
  input logic [7:0]    sreg_i,
  input logic [W-1:0]  result_o,
  input logic          wr_en_o,
  input logic [7:0]    sreg_o,
  input logic          done_o
);
  // R10
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> done_o);
  // R9
  we_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> done_o);
  // R1
  shl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd0) |=> result_o == {$past(operand_i[W-2:0]), 1'b0});
  // R4
  vflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i <= 4'd4) |=> sreg_o[3] == (sreg_o[2] ^ sreg_o[0]));
  // R5
  swap_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd5) |=> sreg_o == $past(sreg_i));
  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd8) |=> sreg_o[$past(idx_i)]);
  // R6
  bst_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd6) |=> !wr_en_o);
endmodule

bind shift_flag_unit shift_flag_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
  .operand_i(operand_i), .idx_i(idx_i), .sreg_i(sreg_i),
  .result_o(result_o), .wr_en_o(wr_en_o), .sreg_o(sreg_o), .done_o(done_o)
);

// File: tb/tb_shift_flag_unit.sv
`timescale 1ns/1ps
module tb_shift_flag_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] operand_i = '0;
  logic [2:0] idx_i = '0;
  logic [7:0] sreg_i = '0;
  logic [7:0] result_o, sreg_o;
  logic       wr_en_o, done_o;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  shift_flag_unit dut (.*);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s op=%0d opnd=%02h idx=%0d sreg=%02h: actual=%0h expected=%0h",
               tag, op_i, operand_i, idx_i, sreg_i, act, exp);
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int pats[5] = '{8'h00, 8'hFF, 8'h01, 8'h40, 8'hA5};
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset result", result_o, 0);
    check("R10 reset sreg", sreg_o, 0);
    check("R10 reset done", done_o, 0);
    check("R10 reset wr_en", wr_en_o, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int op = 0; op < 16; op++) begin
      for (int p = 0; p < 5; p++) begin
        for (int v = 0; v < 256; v++) begin
          int a, s, k, c, r, f, we, n;
          a = v; s = pats[p]; k = (v + op + p) % 8; c = s % 2;
          r = a; f = s; we = 0;
          case (op)
            0: begin r = (a * 2) % 256; c = a / 128; end
            1: begin r = a / 2; c = a % 2; end
            2: begin r = (a * 2) % 256 + c; c = a / 128; end
            3: begin r = a / 2 + 128 * c; c = a % 2; end
            4: begin r = a / 2 + (a / 128) * 128; c = a % 2; end
            5: begin r = (a % 16) * 16 + a / 16; we = 1; end
            6: f = (s & 8'hBF) | (((a >> k) & 1) << 6);
            7: begin r = (a & ~(1 << k) & 8'hFF) | (((s >> 6) & 1) << k); we = 1; end
            8: f = s | (1 << k);
            9: f = s & ~(1 << k) & 8'hFF;
            default: ;
          endcase
          if (op <= 4) begin
            we = 1;
            n = r / 128;
            f = (s & 8'hE0) | c | ((r == 0) << 1) | (n << 2)
                | ((n ^ c) << 3) | ((n ^ (n ^ c)) << 4);
          end
          @(negedge clk);
          valid_i = 1'b1; op_i = op[3:0]; operand_i = a[7:0];
          idx_i = k[2:0]; sreg_i = s[7:0];
          @(posedge clk); #1;
          check("R10 done", done_o, 1);
          case (op)
            0, 1: begin check("R1 result", result_o, r); check("R4 flags", sreg_o, f); end
            2, 3: begin check("R2 result", result_o, r); check("R4 flags", sreg_o, f); end
            4: begin check("R3 result", result_o, r); check("R4 flags", sreg_o, f); end
            5: begin check("R5 result", result_o, r); check("R5 flags", sreg_o, f); end
            6: begin check("R6 flags", sreg_o, f); check("R6 result", result_o, r); end
            7: begin check("R7 result", result_o, r); check("R7 flags", sreg_o, f); end
            8, 9: begin check("R8 flags", sreg_o, f); check("R8 result", result_o, r); end
            default: begin check("R9 result", result_o, r); check("R9 flags", sreg_o, f); end
          endcase
          check("R9 wr_en", wr_en_o, we);
          if (v % 64 == 63) begin
            @(negedge clk); valid_i = 1'b0;
            @(posedge clk); #1;
            check("R10 idle done", done_o, 0);
            check("R10 idle wr_en", wr_en_o, 0);
          end
        end
      end
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule